// File: doc/BRIEF.md
# Hardware Breakpoint Match Unit

This block watches the access events of a processor core and decides, every cycle, whether one of four programmable hardware breakpoints has been hit. Each event carries a kind (instruction fetch, data read, data write or I/O access), a start address and a byte count. Each breakpoint slot has a 64-bit address register. A packed control word holds, for each slot, two enable bits, a two-bit access-condition field and a two-bit length field. When an armed slot matches an event, the block records the hit in a sticky status register. One clock later it emits a one-cycle trap request.

Software reaches all six registers through a simple register port. Reads are combinational. Writes take effect at the next clock edge. A protection mode, general detect, can be switched on in the control word. While it is on, the next register access is refused and raises a trap. That trap also sets a status bit and switches the protection off, so the handler can then reach the registers. A separate single-step input sets its own status bit.

Top module: `bkpt_match_unit`

## Requirements
- R1: After a synchronous reset every register reads zero and `trap_o` is low.
- R2: `reg_sel` selects a register as follows: 0 to 3 are the slot address registers (full 64 bits, read and write), 4 is status and 5 is control. Selects 6 and 7 read zero, and writes to them change nothing.
- R3: A control write changes only bits 0 to 9, 11, 13 and 16 to 31. Every other control bit keeps its value and reads zero.
- R4: Slot n is armed when control bit 2n or bit 2n+1 is set. A slot with both bits clear never matches.
- R5: The condition field of slot n sits at control bits 17+4n:16+4n. Its codes are 00 (fetch only), 01 (data write only), 10 (I/O only) and 11 (data read or data write). `acc_kind` uses 00 for fetch, 01 for data read, 10 for data write and 11 for I/O.
- R6: The length field of slot n sits at control bits 19+4n:18+4n. Its codes are 00 (1 byte), 01 (2 bytes), 10 (8 bytes) and 11 (4 bytes). The watched range begins at the slot address rounded down to a multiple of that length and spans that length. An event matches when its bytes `acc_addr` to `acc_addr+acc_len-1` overlap the watched range. An `acc_len` of 0 counts as 1.
- R7: For condition 00 the length field is ignored, and only the single byte at the slot address is watched.
- R8: A match on slot n sets status bit n. Status bits stay set until software writes the status register. That write loads bits 0 to 3, 13 and 14 from the write data, and the other status bits read zero.
- R9: `trap_o` is high for exactly the cycle after a cycle with a slot match or a refused register access, and is low otherwise.
- R10: While control bit 13 is set, a register access is refused: a write is dropped and a read returns zero. The refused access also sets status bit 13 and clears control bit 13.
- R11: `step_in` high in a cycle sets status bit 14 at the next edge.
- R12: When a hit, a step or a refused access coincides with a status write, the set of that status bit takes priority over the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_req | input | 1 | Register access this cycle |
| reg_we | input | 1 | Access is a write |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | ADDR_W | Write data |
| reg_rdata | output | ADDR_W | Read data (combinational) |
| acc_valid | input | 1 | Access event present |
| acc_kind | input | 2 | Event kind |
| acc_addr | input | ADDR_W | Event start address |
| acc_len | input | 4 | Event byte count, 1 to 8 |
| step_in | input | 1 | Single-step trap indication |
| trap_o | output | 1 | Registered one-cycle trap request |

## Verification
Directed events probe each slot at the first and last byte of its watched range, one byte past each end, and with wide accesses that straddle the range start. These tell a correct overlap test apart from plain address equality and from off-by-one errors at either end. Each condition code is tried against all four event kinds, and the 8-byte and 4-byte length codes are used on the same run, so a swapped length decode or a wrong kind filter shows up. A long random phase then mixes events near all four ranges with status writes and step pulses, and a behavioural byte-by-byte model is compared against the design on every clock.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

    localparam int NUM_SLOTS = 4;
    localparam int LEN_W     = 4;
    localparam int CTRL_W    = 32;
    localparam int STAT_W    = 16;
    localparam int GD_BIT    = 13;
    localparam int STEP_BIT  = 14;
    localparam int FIELD_LSB = 16;

    localparam logic [CTRL_W-1:0] CTRL_WMASK = 32'hFFFF_2BFF;
    localparam logic [STAT_W-1:0] STAT_MASK  = 16'h600F;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'b00,
        ACC_READ  = 2'b01,
        ACC_WRITE = 2'b10,
        ACC_IO    = 2'b11
    } acc_kind_e;

    typedef enum logic [1:0] {
        WATCH_EXEC = 2'b00,
        WATCH_WR   = 2'b01,
        WATCH_IO   = 2'b10,
        WATCH_RW   = 2'b11
    } watch_cond_e;

    typedef enum logic [2:0] {
        SEL_SLOT0  = 3'd0,
        SEL_SLOT1  = 3'd1,
        SEL_SLOT2  = 3'd2,
        SEL_SLOT3  = 3'd3,
        SEL_STATUS = 3'd4,
        SEL_CTRL   = 3'd5
    } reg_sel_e;

    typedef struct packed {
        logic        armed;
        watch_cond_e cond;
        logic [1:0]  len_code;
    } slot_cfg_t;

    // Length code to byte count; the code order is not monotonic.
    function automatic logic [LEN_W-1:0] len_bytes(input logic [1:0] code);
        logic [LEN_W-1:0] b;
        case (code)
            2'b00:   b = LEN_W'(1);
            2'b01:   b = LEN_W'(2);
            2'b10:   b = LEN_W'(8);
            default: b = LEN_W'(4);
        endcase
        return b;
    endfunction

    function automatic slot_cfg_t slot_cfg(input logic [CTRL_W-1:0] ctrl, input int n);
        slot_cfg_t c;
        c.armed    = ctrl[2*n] | ctrl[2*n+1];
        c.cond     = watch_cond_e'(ctrl[FIELD_LSB + 4*n +: 2]);
        c.len_code = ctrl[FIELD_LSB + 4*n + 2 +: 2];
        return c;
    endfunction

    function automatic logic cond_accepts(input watch_cond_e c, input acc_kind_e k);
        logic ok;
        case (c)
            WATCH_EXEC: ok = (k == ACC_FETCH);
            WATCH_WR:   ok = (k == ACC_WRITE);
            WATCH_IO:   ok = (k == ACC_IO);
            default:    ok = (k == ACC_READ) || (k == ACC_WRITE);
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/bkpt_slot.sv
module bkpt_slot
    import bkpt_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  slot_cfg_t                cfg,
    input  logic [ADDR_W-1:0]        bp_addr,
    input  logic                     acc_valid,
    input  acc_kind_e                acc_kind,
    input  logic [ADDR_W-1:0]        acc_addr,
    input  logic [LEN_W-1:0]         acc_len,
    output logic                     hit
);
    localparam int EXT_W = ADDR_W + 1;

    logic [LEN_W-1:0]  span;
    logic [LEN_W-1:0]  acc_span;
    logic [ADDR_W-1:0] low_mask;
    logic [ADDR_W-1:0] base;
    logic [EXT_W-1:0]  bp_last;
    logic [EXT_W-1:0]  acc_last;
    logic              overlap;

    always_comb begin
        // Execution watches one byte regardless of the length field.
        span     = (cfg.cond == WATCH_EXEC) ? LEN_W'(1) : len_bytes(cfg.len_code);
        acc_span = (acc_len == '0) ? LEN_W'(1) : acc_len;
        low_mask = ADDR_W'(span) - ADDR_W'(1);
        base     = bp_addr & ~low_mask;
        bp_last  = {1'b0, base} + EXT_W'(span) - EXT_W'(1);
        acc_last = {1'b0, acc_addr} + EXT_W'(acc_span) - EXT_W'(1);
        overlap  = ({1'b0, acc_addr} <= bp_last) && ({1'b0, base} <= acc_last);
        hit      = acc_valid && cfg.armed && cond_accepts(cfg.cond, acc_kind) && overlap;
    end

endmodule

// File: rtl/bkpt_regfile.sv
module bkpt_regfile
    import bkpt_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 reg_req,
    input  logic                                 reg_we,
    input  logic [2:0]                           reg_sel,
    input  logic [ADDR_W-1:0]                    reg_wdata,
    output logic [ADDR_W-1:0]                    reg_rdata,
    input  logic [NUM_SLOTS-1:0]                 slot_hit,
    input  logic                                 step_in,
    output logic [NUM_SLOTS-1:0][ADDR_W-1:0]     bp_addr,
    output logic [CTRL_W-1:0]                    ctrl,
    output logic                                 gd_event
);
    logic [NUM_SLOTS-1:0][ADDR_W-1:0] addr_q;
    logic [CTRL_W-1:0]                ctrl_q;
    logic [STAT_W-1:0]                status_q;
    logic [STAT_W-1:0]                status_d;
    logic                             access_ok;
    logic                             wr_ok;
    logic                             wr_status;
    logic                             wr_ctrl;

    assign gd_event  = reg_req && ctrl_q[GD_BIT];
    assign access_ok = reg_req && !ctrl_q[GD_BIT];
    assign wr_ok     = access_ok && reg_we;
    assign wr_status = wr_ok && (reg_sel == SEL_STATUS);
    assign wr_ctrl   = wr_ok && (reg_sel == SEL_CTRL);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else begin
            for (int n = 0; n < NUM_SLOTS; n++) begin
                if (wr_ok && (reg_sel == 3'(n))) begin
                    addr_q[n] <= reg_wdata;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (gd_event) begin
            ctrl_q[GD_BIT] <= 1'b0;
        end else if (wr_ctrl) begin
            ctrl_q <= (ctrl_q & ~CTRL_WMASK) | (reg_wdata[CTRL_W-1:0] & CTRL_WMASK);
        end
    end

    always_comb begin
        status_d = wr_status ? (reg_wdata[STAT_W-1:0] & STAT_MASK) : status_q;
        status_d[NUM_SLOTS-1:0] = status_d[NUM_SLOTS-1:0] | slot_hit;
        if (gd_event) status_d[GD_BIT]   = 1'b1;
        if (step_in)  status_d[STEP_BIT] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) status_q <= '0;
        else     status_q <= status_d;
    end

    always_comb begin
        reg_rdata = '0;
        if (access_ok) begin
            case (reg_sel)
                SEL_SLOT0, SEL_SLOT1, SEL_SLOT2, SEL_SLOT3:
                    reg_rdata = addr_q[reg_sel[1:0]];
                SEL_STATUS: reg_rdata = ADDR_W'(status_q);
                SEL_CTRL:   reg_rdata = ADDR_W'(ctrl_q);
                default:    reg_rdata = '0;
            endcase
        end
    end

    assign bp_addr = addr_q;
    assign ctrl    = ctrl_q;

    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(reg_req && (ctrl_q[GD_BIT] || (reg_we && reg_sel == SEL_CTRL))) |=> $stable(ctrl_q)); // R3
    AST_STICKY_HITS: assert property (@(posedge clk) disable iff (rst)
        !wr_status |=> ((status_q[NUM_SLOTS-1:0] & $past(status_q[NUM_SLOTS-1:0])) == $past(status_q[NUM_SLOTS-1:0]))); // R8
    AST_HIT_WINS: assert property (@(posedge clk) disable iff (rst)
        (|slot_hit) |=> ((status_q[NUM_SLOTS-1:0] & $past(slot_hit)) == $past(slot_hit))); // R12
    AST_GD_DISARM: assert property (@(posedge clk) disable iff (rst)
        gd_event |=> (!ctrl_q[GD_BIT] && status_q[GD_BIT])); // R10
    AST_STEP_SET: assert property (@(posedge clk) disable iff (rst)
        step_in |=> status_q[STEP_BIT]); // R11

endmodule

// File: rtl/bkpt_match_unit.sv
module bkpt_match_unit
    import bkpt_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_req,
    input  logic              reg_we,
    input  logic [2:0]        reg_sel,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    input  logic              acc_valid,
    input  logic [1:0]        acc_kind,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [3:0]        acc_len,
    input  logic              step_in,
    output logic              trap_o
);
    logic [NUM_SLOTS-1:0][ADDR_W-1:0] bp_addr;
    logic [CTRL_W-1:0]                ctrl;
    logic [NUM_SLOTS-1:0]             slot_hit;
    logic                             gd_event;
    logic                             trap_q;

    bkpt_regfile #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_req   (reg_req),
        .reg_we    (reg_we),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .slot_hit  (slot_hit),
        .step_in   (step_in),
        .bp_addr   (bp_addr),
        .ctrl      (ctrl),
        .gd_event  (gd_event)
    );

    for (genvar n = 0; n < NUM_SLOTS; n++) begin : g_slot
        bkpt_slot #(.ADDR_W(ADDR_W)) u_slot (
            .cfg       (slot_cfg(ctrl, n)),
            .bp_addr   (bp_addr[n]),
            .acc_valid (acc_valid),
            .acc_kind  (acc_kind_e'(acc_kind)),
            .acc_addr  (acc_addr),
            .acc_len   (acc_len),
            .hit       (slot_hit[n])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) trap_q <= 1'b0;
        else     trap_q <= (|slot_hit) || gd_event;
    end

    assign trap_o = trap_q;

    AST_TRAP_CAUSE: assert property (@(posedge clk) disable iff (rst)
        trap_o |-> $past((|slot_hit) || gd_event)); // R9
    AST_TRAP_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        ((|slot_hit) || gd_event) |=> trap_o); // R9
    AST_IDLE_NO_HIT: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |-> (slot_hit == '0)); // R6
    AST_ARMED_ONLY: assert property (@(posedge clk) disable iff (rst)
        (ctrl[7:0] == 8'h00) |-> (slot_hit == '0)); // R4

endmodule

// File: tb/sim_bkpt_match_unit.sv
`timescale 1ns/1ps
module sim_bkpt_match_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        reg_req, reg_we;
    logic [2:0]  reg_sel;
    logic [63:0] reg_wdata, reg_rdata;
    logic        acc_valid;
    logic [1:0]  acc_kind;
    logic [63:0] acc_addr;
    logic [3:0]  acc_len;
    logic        step_in;
    logic        trap_o;

    int n_cmp = 0;
    int n_bad = 0;

    // Reference state
    logic [63:0] m_addr [4];
    logic [31:0] m_ctrl;
    logic [15:0] m_stat;
    logic        m_trap;

    always #4 clk = ~clk;

    bkpt_match_unit u0 (
        .clk(clk), .rst(rst), .reg_req(reg_req), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_valid(acc_valid),
        .acc_kind(acc_kind), .acc_addr(acc_addr), .acc_len(acc_len),
        .step_in(step_in), .trap_o(trap_o)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit model_hit(input int n);
        bit armed;
        int cond, lc, blen, alen;
        logic [64:0] base, b;
        armed = m_ctrl[2*n] | m_ctrl[2*n+1];
        cond  = int'((m_ctrl >> (16 + 4*n)) & 32'h3);
        lc    = int'((m_ctrl >> (18 + 4*n)) & 32'h3);
        if (!armed) return 0;
        case (cond)
            0: if (acc_kind != 2'b00) return 0;
            1: if (acc_kind != 2'b10) return 0;
            2: if (acc_kind != 2'b11) return 0;
            default: if (acc_kind != 2'b01 && acc_kind != 2'b10) return 0;
        endcase
        if (cond == 0) blen = 1;
        else if (lc == 0) blen = 1;
        else if (lc == 1) blen = 2;
        else if (lc == 2) blen = 8;
        else blen = 4;
        base = {1'b0, m_addr[n]} - ({1'b0, m_addr[n]} % 65'(blen));
        alen = (acc_len == 0) ? 1 : int'(acc_len);
        for (int i = 0; i < alen; i++) begin
            b = {1'b0, acc_addr} + 65'(i);
            if (b >= base && b < base + 65'(blen)) return 1;
        end
        return 0;
    endfunction

    function automatic logic [63:0] model_rdata();
        if (!reg_req || m_ctrl[13]) return 64'h0;
        case (reg_sel)
            3'd0, 3'd1, 3'd2, 3'd3: return m_addr[reg_sel[1:0]];
            3'd4: return {48'h0, m_stat};
            3'd5: return {32'h0, m_ctrl};
            default: return 64'h0;
        endcase
    endfunction

    // One clock: compare outputs mid-cycle, then advance the model at the edge.
    task automatic tick(input string tag);
        logic [3:0]  hits;
        bit          gd, ok;
        logic [15:0] ns;
        #1;
        if (!rst) begin
            check({tag, " rdata"}, reg_rdata, model_rdata());
            check("R9 trap", {63'h0, trap_o}, {63'h0, m_trap});
        end
        hits = '0;
        if (acc_valid) for (int n = 0; n < 4; n++) if (model_hit(n)) hits[n] = 1'b1;
        gd = reg_req && m_ctrl[13];
        ok = reg_req && !m_ctrl[13];
        @(posedge clk);
        if (rst) begin
            for (int n = 0; n < 4; n++) m_addr[n] = '0;
            m_ctrl = '0; m_stat = '0; m_trap = 1'b0;
        end else begin
            ns = m_stat;
            if (ok && reg_we && reg_sel == 3'd4) ns = reg_wdata[15:0] & 16'h600F;
            ns[3:0] = ns[3:0] | hits;
            if (gd) ns[13] = 1'b1;
            if (step_in) ns[14] = 1'b1;
            if (ok && reg_we && reg_sel < 3'd4) m_addr[reg_sel[1:0]] = reg_wdata;
            if (gd) m_ctrl[13] = 1'b0;
            else if (ok && reg_we && reg_sel == 3'd5)
                m_ctrl = (m_ctrl & ~32'hFFFF2BFF) | (reg_wdata[31:0] & 32'hFFFF2BFF);
            m_stat = ns;
            m_trap = (hits != 0) || gd;
        end
        @(negedge clk);
    endtask

    task automatic idle();
        reg_req = 0; reg_we = 0; reg_sel = 0; reg_wdata = 0;
        acc_valid = 0; acc_kind = 0; acc_addr = 0; acc_len = 0; step_in = 0;
    endtask

    task automatic wr(input logic [2:0] s, input logic [63:0] d, input string tag);
        idle(); reg_req = 1; reg_we = 1; reg_sel = s; reg_wdata = d; tick(tag);
    endtask

    task automatic rd(input logic [2:0] s, input logic [63:0] exp, input string tag);
        idle(); reg_req = 1; reg_sel = s;
        #1 check({tag, " readback"}, reg_rdata, exp);
        tick(tag);
    endtask

    task automatic ev(input logic [1:0] k, input logic [63:0] a, input logic [3:0] l,
                      input bit exp_trap, input string tag);
        idle(); acc_valid = 1; acc_kind = k; acc_addr = a; acc_len = l; tick(tag);
        idle(); #1 check({tag, " trap next cycle"}, {63'h0, trap_o}, {63'h0, exp_trap});
        tick(tag);
    endtask

    initial begin
        idle(); rst = 1;
        repeat (3) tick("R1");
        rst = 0;
        for (int s = 0; s < 6; s++) rd(3'(s), 64'h0, "R1");
        check("R1 trap idle", {63'h0, trap_o}, 64'h0);

        // R2 address registers and unused selects
        wr(3'd0, 64'h0000_0000_0000_1000, "R2");
        wr(3'd1, 64'h0000_0000_0000_2005, "R2");
        wr(3'd2, 64'h0000_0000_0000_3006, "R2");
        wr(3'd3, 64'h0000_0000_0000_4001, "R2");
        wr(3'd6, 64'hFFFF_FFFF_FFFF_FFFF, "R2");
        wr(3'd7, 64'hFFFF_FFFF_FFFF_FFFF, "R2");
        rd(3'd2, 64'h3006, "R2");
        rd(3'd6, 64'h0, "R2");
        rd(3'd7, 64'h0, "R2");
        rd(3'd3, 64'h4001, "R2");

        // R3 writable mask; this also arms general detect (bit 13)
        wr(3'd5, 64'hFFFF_FFFF_FFFF_FFFF, "R3");
        // R10 the next access is refused
        rd(3'd5, 64'h0, "R10");
        idle(); #1 check("R10 trap after refused access", {63'h0, trap_o}, 64'h1);
        tick("R10");
        rd(3'd5, 64'hFFFF_0BFF, "R3");
        rd(3'd4, 64'h2000, "R10");
        // refused write is dropped
        wr(3'd5, 64'h2000, "R10");
        wr(3'd0, 64'hDEAD, "R10");
        rd(3'd0, 64'h1000, "R10");

        // Slot setup: s0 exec(len 11 ignored), s1 write 8B, s2 io 4B, s3 rw 2B
        wr(3'd5, 64'h7E9C_0099, "R5");
        wr(3'd4, 64'h0, "R8");
        rd(3'd4, 64'h0, "R8");

        ev(2'b00, 64'h1000, 4'd4, 1, "R5 fetch hit");
        ev(2'b00, 64'h0FFF, 4'd1, 0, "R6 fetch below");
        ev(2'b00, 64'h0FFE, 4'd4, 1, "R6 straddle");
        ev(2'b01, 64'h1000, 4'd1, 0, "R5 read on exec slot");
        ev(2'b00, 64'h1001, 4'd1, 0, "R7 length ignored");
        ev(2'b10, 64'h2007, 4'd1, 1, "R6 8B top byte");
        ev(2'b10, 64'h2000, 4'd1, 1, "R6 8B aligned base");
        ev(2'b10, 64'h2008, 4'd1, 0, "R6 8B past end");
        ev(2'b01, 64'h2000, 4'd1, 0, "R5 read on write slot");
        ev(2'b11, 64'h3003, 4'd2, 1, "R6 4B straddle");
        ev(2'b11, 64'h3008, 4'd1, 0, "R6 4B past end");
        ev(2'b10, 64'h3004, 4'd1, 0, "R5 write on io slot");
        ev(2'b01, 64'h4001, 4'd1, 1, "R5 read on rw slot");
        ev(2'b10, 64'h3FFF, 4'd2, 1, "R6 2B straddle");
        ev(2'b00, 64'h4000, 4'd1, 0, "R5 fetch on rw slot");
        ev(2'b11, 64'h4000, 4'd1, 0, "R5 io on rw slot");
        ev(2'b01, 64'h3FFE, 4'd0, 0, "R6 zero length");
        rd(3'd4, 64'h000F, "R8 sticky");

        // R4 enables
        wr(3'd5, 64'h7E9C_0098, "R4");
        ev(2'b00, 64'h1000, 4'd1, 0, "R4 disarmed");
        wr(3'd5, 64'h7E9C_009A, "R4");
        ev(2'b00, 64'h1000, 4'd1, 1, "R4 global only");

        // R12 hit and step coincide with a status clear
        idle(); reg_req = 1; reg_we = 1; reg_sel = 3'd4; reg_wdata = 64'h0;
        acc_valid = 1; acc_kind = 2'b10; acc_addr = 64'h2003; acc_len = 4'd1; step_in = 1;
        tick("R12");
        rd(3'd4, 64'h4002, "R12");
        // R8 status write loads only defined bits
        wr(3'd4, 64'hFFFF_FFFF_FFFF_FFFF, "R8");
        rd(3'd4, 64'h600F, "R8");
        wr(3'd4, 64'h0, "R8");
        // R11 step
        idle(); step_in = 1; tick("R11");
        rd(3'd4, 64'h4000, "R11");

        // Random mix against the model
        for (int i = 0; i < 3000; i++) begin
            idle();
            acc_valid = ($urandom_range(0, 3) != 0);
            acc_kind  = 2'($urandom_range(0, 3));
            acc_addr  = 64'h0FF8 + 64'($urandom_range(0, 4)) * 64'h1000 + 64'($urandom_range(0, 16));
            acc_len   = 4'($urandom_range(1, 8));
            step_in   = ($urandom_range(0, 15) == 0);
            case ($urandom_range(0, 9))
                0: begin reg_req = 1; reg_we = 1; reg_sel = 3'd4; reg_wdata = 64'($urandom()); end
                1: begin reg_req = 1; reg_sel = 3'($urandom_range(0, 5)); end
                default: ;
            endcase
            tick("R6 random");
        end
        idle(); tick("R9");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule